// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the protocol core of a 2K x 8 serial EEPROM that sits on an I2C bus as a slave. Its inputs are the sampled SCL and SDA levels and one-cycle Start and Stop events from a glitch filter placed ahead of it. Its output is a single enable that pulls SDA low on the open-drain line. The block decodes the control byte that opens each transfer, loads an 11-bit address pointer and gathers write data in a 16-byte page buffer. When a Stop arrives, it copies the buffered bytes into a synchronous RAM that stands in for the array. At the same moment it raises a one-cycle request to an external write-cycle timer.

Read transfers are served straight from the RAM, MSB first. The pointer advances after every byte sent, so a read can continue from where the last access left off, start at a freshly loaded address, or stream through the whole array. For as long as the timer reports busy, the engine acknowledges nothing. A host can therefore poll with control bytes until an acknowledge returns.

Top module: `eeprom_i2c_engine`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0) and no write-cycle request is raised.
- R2: The first byte after a Start is a control byte. Bits 7..4 must equal 1010, bits 3..1 are address bits 10..8, and bit 0 selects read (1) or write (0). It is acknowledged by holding SDA low for the whole ninth clock only when the code matches. On a mismatch, no acknowledge is given and all further bytes are ignored until the next Start.
- R3: In a write, the second byte sets address bits 7..0. Each data byte is acknowledged and buffered at the pointer, and then only the pointer's low 4 bits advance. Bytes past the end of a 16-byte page wrap to its start, and later bytes replace earlier ones.
- R4: Buffered data reaches the array only on a Stop. That Stop also raises `wcyc_start_o` for exactly one cycle. A Start, including a repeated Start, discards buffered data and requests nothing.
- R5: While `wcyc_busy_i` is high or the buffer is being copied, no byte of any kind is acknowledged, including a polling control byte.
- R6: A random read sends a write control byte and an address byte, then a repeated Start and a read control byte. It returns the data at that address.
- R7: A read control byte that follows a Start without a new address returns the data at the pointer, which is one past the last byte accessed. Its bits 3..1 are ignored.
- R8: Read data is sent MSB first, and SDA changes on SCL falling edges. A master acknowledge makes the engine send the byte at the next address. The pointer wraps from 0x7FF to 0x000.
- R9: After a master not-acknowledge, the engine releases SDA and drives nothing until the next Start.
- R10: The engine's SDA enable never changes while SCL stays high, except in response to Start or Stop.
- R11: A Start or Stop in the middle of a byte abandons the transfer and releases SDA. A Start then waits for a control byte, and a partly received address byte leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| start_i | input | 1 | One-cycle Start event |
| stop_i | input | 1 | One-cycle Stop event |
| wcyc_busy_i | input | 1 | Write-cycle timer busy |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wcyc_start_o | output | 1 | One-cycle request to start a write cycle |

## Verification
An SCL edge is seen in the first clock after it reaches `scl_i`. Any acknowledge or data bit it triggers appears on `sda_oe_o` in that same clock, so every slave bit is settled one cycle after a falling SCL edge. The bench holds each SCL half-period for four clocks and samples SDA two clocks into the high phase, well clear of that update. The write-cycle request follows the Stop event by one clock. The bench counts requests in a monitor and reads that count only after the Stop task has ended. Acknowledge polling then loops until an acknowledge appears, so no fixed latency is assumed for the write cycle.

// File: rtl/eeprom_i2c_engine.sv
module eeprom_i2c_engine #(
  parameter int         AW  = 11,
  parameter int         PW  = 4,
  parameter logic [3:0] DEV = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic wcyc_busy_i,
  output logic sda_oe_o,
  output logic wcyc_start_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGES = 1 << PW;
  localparam int HI    = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDAT, S_TX, S_WAIT} st_t;

  st_t             st;
  logic [3:0]      cnt;
  logic [7:0]      sh, rdata;
  logic [AW-1:0]   ptr;
  logic [HI-1:0]   blk;
  logic            scl_q, oe, mack, wstart, cm_act;
  logic [PW-1:0]   cm_idx;
  logic [PAGES-1:0] pval;
  logic [AW-PW-1:0] pg;
  logic [7:0]      pbuf [0:PAGES-1];
  logic [7:0]      mem  [0:DEPTH-1];

  wire ev    = start_i | stop_i;
  wire rise  = !ev &  scl_i & ~scl_q;
  wire fall  = !ev & ~scl_i &  scl_q;
  wire busy  = wcyc_busy_i | cm_act;
  wire rx    = (st == S_CTRL) || (st == S_ADDR) || (st == S_WDAT);
  wire wd_we = fall && (cnt == 4'd8) && (st == S_WDAT) && !busy;

  assign sda_oe_o     = oe;
  assign wcyc_start_o = wstart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ptr <= '0; blk <= '0;
      scl_q <= 1'b1; oe <= 1'b0; mack <= 1'b0; wstart <= 1'b0;
      cm_act <= 1'b0; cm_idx <= '0; pval <= '0; pg <= '0;
    end else begin
      scl_q  <= scl_i;
      wstart <= 1'b0;
      if (cm_act) begin
        pval[cm_idx] <= 1'b0;
        cm_idx       <= cm_idx + 1'b1;
        if (&cm_idx) cm_act <= 1'b0;
      end
      if (start_i) begin
        st <= S_CTRL; cnt <= '0; oe <= 1'b0;
        if (!cm_act) pval <= '0;
      end else if (stop_i) begin
        st <= S_IDLE; cnt <= '0; oe <= 1'b0;
        if (!cm_act) begin
          if (|pval) begin
            cm_act <= 1'b1; cm_idx <= '0; wstart <= 1'b1;
          end else pval <= '0;
        end
      end else if (rise) begin
        if (cnt < 4'd8) begin
          if (rx) sh <= {sh[6:0], sda_i};
          if (st != S_IDLE && st != S_WAIT) cnt <= cnt + 1'b1;
        end else if (cnt == 4'd8) begin
          cnt  <= 4'd9;
          mack <= ~sda_i;
        end
      end else if (fall) begin
        if (rx) begin
          if (cnt == 4'd8) begin
            if (busy) st <= S_WAIT;
            else if (st == S_CTRL) begin
              if (sh[7:4] == DEV) begin
                oe  <= 1'b1;
                blk <= sh[HI:1];
                st  <= sh[0] ? S_TX : S_ADDR;
              end else st <= S_WAIT;
            end else if (st == S_ADDR) begin
              ptr <= {blk, sh};
              oe  <= 1'b1;
              st  <= S_WDAT;
            end else begin
              pval[ptr[PW-1:0]] <= 1'b1;
              pg  <= ptr[AW-1:PW];
              ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
              oe  <= 1'b1;
            end
          end else if (cnt == 4'd9) begin
            oe  <= 1'b0;
            cnt <= '0;
          end
        end else if (st == S_TX) begin
          if (cnt == 4'd9) begin
            if (mack) begin
              sh  <= rdata;
              ptr <= ptr + 1'b1;
              oe  <= ~rdata[7];
              cnt <= '0;
            end else begin
              oe <= 1'b0;
              st <= S_WAIT;
            end
          end else if (cnt == 4'd8) oe <= 1'b0;
          else if (cnt != 4'd0) begin
            sh <= {sh[6:0], 1'b0};
            oe <= ~sh[6];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wd_we) pbuf[ptr[PW-1:0]] <= sh;
    if (cm_act && pval[cm_idx]) mem[{pg, cm_idx}] <= pbuf[cm_idx];
    rdata <= mem[ptr];
  end
endmodule

module eeprom_i2c_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic start_i,
  input logic stop_i,
  input logic wcyc_busy_i,
  input logic sda_oe_o,
  input logic wcyc_start_o
);
  p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(sda_oe_o));

  p_busy_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(wcyc_busy_i));

  p_commit_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_start_o |-> $past(stop_i));

  p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_start_o |=> !wcyc_start_o);

  p_event_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_i) || $past(stop_i)) |-> !sda_oe_o);
endmodule

bind eeprom_i2c_engine eeprom_i2c_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .start_i(start_i), .stop_i(stop_i),
  .wcyc_busy_i(wcyc_busy_i), .sda_oe_o(sda_oe_o), .wcyc_start_o(wcyc_start_o)
);

// File: tb/eeprom_i2c_engine_test.sv
module eeprom_i2c_engine_test;
  localparam int H = 4;
  localparam int BUSY_CYC = 200;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic sda_oe, wstart;
  int   bcnt = 0, wstarts = 0, errors = 0, checks = 0, ref_ptr = 0;
  logic [7:0] ref_mem [0:2047];
  logic [7:0] wdat [0:31];

  wire sda_bus = sda_m & ~sda_oe;
  wire busy    = (bcnt != 0);

  always #5 clk = ~clk;

  eeprom_i2c_engine uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .start_i(start_i),
    .stop_i(stop_i), .wcyc_busy_i(busy), .sda_oe_o(sda_oe), .wcyc_start_o(wstart)
  );

  always @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else if (wstart) begin bcnt <= BUSY_CYC; wstarts <= wstarts + 1; end
    else if (bcnt != 0) bcnt <= bcnt - 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int paddr(input int b, input int k);
    return (b & 'h7F0) | ((b + k) & 'hF);
  endfunction

  function automatic logic [7:0] ctrl(input int a, input bit r);
    return {4'hA, 3'((a >> 8) & 7), r};
  endfunction

  task automatic bstart();
    sda_m = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    sda_m = 1'b0; start_i = 1'b1; tick(1); start_i = 1'b0;
    tick(H); scl = 1'b0; tick(1);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    sda_m = 1'b1; stop_i = 1'b1; tick(1); stop_i = 1'b0;
    tick(H);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(1);
  endtask

  task automatic send(input logic [7:0] b, output logic ak);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; tick(H);
    scl = 1'b1; tick(2);
    ak = !sda_bus;
    tick(H - 2); scl = 1'b0; tick(1);
  endtask

  task automatic recv(input bit mack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(H);
      scl = 1'b1; tick(2);
      d = {d[6:0], sda_bus};
      tick(H - 2); scl = 1'b0; tick(1);
    end
    sda_m = !mack; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(1);
    sda_m = 1'b1;
  endtask

  task automatic wr(input int a, input int n);
    logic ak;
    bstart();
    send(ctrl(a, 1'b0), ak); chk("R2 write control ack", ak, 1);
    send(8'(a), ak);         chk("R3 address ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      send(wdat[k], ak);     chk("R3 data ack", ak, 1);
      ref_mem[paddr(a, k)] = wdat[k];
    end
    bstop();
    ref_ptr = paddr(a, n);
  endtask

  task automatic wait_ready();
    logic ak = 1'b0;
    for (int t = 0; t < 60 && !ak; t++) begin
      bstart(); send(8'hA0, ak); bstop();
    end
    chk("R5 poll finally acked", ak, 1);
  endtask

  task automatic rd(input int a, input int n, input bit rnd, input logic [2:0] br, input string tag);
    logic ak;
    logic [7:0] d;
    int s;
    s = rnd ? a : ref_ptr;
    if (rnd) begin
      bstart();
      send(ctrl(a, 1'b0), ak); chk("R6 control ack", ak, 1);
      send(8'(a), ak);         chk("R6 address ack", ak, 1);
    end
    bstart();
    send({4'hA, br, 1'b1}, ak); chk("R2 read control ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      recv(k != n - 1, d);
      chk(tag, int'(d), int'(ref_mem[(s + k) & 'h7FF]));
    end
    tick(1);
    chk("R9 released after nack", int'(sda_oe), 0);
    recv(1'b0, d);
    chk("R9 silent until start", int'(d), 'hFF);
    bstop();
    ref_ptr = (s + n) & 'h7FF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] d;
    int w0;
    void'($urandom(1234));
    tick(5); rst_n = 1'b1; tick(2);
    chk("R1 sda released", int'(sda_oe), 0);
    chk("R1 no request", int'(wstart), 0);

    bstart();
    send(8'h5A, ak); chk("R2 wrong code nack", ak, 0);
    send(8'h00, ak); chk("R2 ignored after mismatch", ak, 0);
    bstop();
    chk("R2 no write after mismatch", wstarts, 0);

    wdat[0] = 8'h5C;
    wr('h3A5, 1);
    chk("R4 one request on stop", wstarts, 1);
    bstart(); send(8'hA0, ak); bstop();
    chk("R5 poll nack while busy", ak, 0);
    bstart(); send(ctrl('h3A5, 1'b1), ak); bstop();
    chk("R5 read control nack while busy", ak, 0);
    wait_ready();

    for (int k = 0; k < 18; k++) wdat[k] = 8'(8'h80 + k);
    wr('h12E, 18);
    wait_ready();
    chk("R3 page rollover model", int'(ref_mem['h12E]), 'h90);
    rd('h12E, 1, 1'b1, 3'b000, "R3 rollover data");
    rd(0, 1, 1'b0, 3'b111, "R7 current address read");
    rd('h120, 16, 1'b1, 3'b000, "R8 sequential read");

    for (int k = 0; k < 16; k++) wdat[k] = 8'($urandom);
    wr('h7F0, 16); wait_ready();
    for (int k = 0; k < 16; k++) wdat[k] = 8'($urandom);
    wr('h000, 16); wait_ready();
    rd('h7FD, 6, 1'b1, 3'b000, "R8 wrap 7FF to 000");

    w0 = wstarts;
    bstart();
    send(ctrl('h3A5, 1'b0), ak);
    send(8'hA5, ak);
    send(8'hEE, ak);
    rd('h3A5, 1, 1'b1, 3'b000, "R4 repeated start discards data");
    chk("R4 no request after repeated start", wstarts, w0);

    bstart();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    rd('h120, 2, 1'b1, 3'b000, "R11 start mid byte");
    bstart();
    send(ctrl('h125, 1'b0), ak);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    bstop();
    rd(0, 1, 1'b0, 3'b000, "R11 stop mid byte keeps pointer");

    for (int it = 0; it < 10; it++) begin
      int p, off, n, a;
      p   = $urandom_range(8, 63);
      off = $urandom_range(0, 15);
      n   = 1 + $urandom_range(0, 15 - off);
      a   = p * 16 + off;
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      wr(a, n);
      wait_ready();
      rd(a, n, 1'b1, 3'($urandom), "R6 random read back");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule